// File: doc/BRIEF.md
# Error-Detection Packet Presence Detector and Unknown-Error-Status Updater

This block watches the received 10-bit word stream of a serial digital video link, one word per clock, together with the line and sample counts that a timing block upstream supplies. In every field it looks for the error-detection ancillary packet. It treats the packet as present only when the exact header appears with its first word at the line and sample that the selected video standard expects. It then takes in the three flag words that follow the header.

At the end of each field, marked by a one-cycle strobe, the block registers a missing-packet flag. It also registers the three outgoing "unknown error status" (UES) bits for the ancillary, active-picture and full-field regions. A present packet passes each incoming UES bit through. A region whose validity bit is low has its outgoing UES bit forced high. A field with no packet forces all three high. The results hold until the next strobe, so a downstream packet builder or an error counter reads stable values for a whole field.

The header matcher is an enumerated state machine, `hdr_state_e`, with these states:
- `ST_HUNT`: waiting for a first word.
- `ST_GOT0`, `ST_GOT1`, `ST_GOT2`: one, two or three header words matched.
- `ST_CAP_AP`, `ST_CAP_FF`, `ST_CAP_ANC`: taking the flag words.
- `ST_DONE`: packet complete for this field.

Its transitions are:
- HUNT to GOT0 on word 000h.
- GOT0 to GOT1 on 3FFh.
- GOT1 to GOT2 on 3FFh.
- GOT2 to CAP_AP on 1F4h, but only if the 000h word came at the expected slot. Otherwise GOT2 returns to HUNT.
- From any GOTn state, word 000h goes to GOT0, which restarts the header. Any other word goes back to HUNT.
- CAP_AP to CAP_FF to CAP_ANC to DONE, one word each.
- DONE holds its state.
- The field-end strobe sends every state to HUNT.

Top module: `edh_presence_ues`

## Requirements
- R1: After reset, `no_pkt_o` is 1 and `ues_o` is 3'b111.
- R2: The header is recognised only as the four consecutive words 000h, 3FFh, 3FFh, 1F4h. Any other word inside the sequence abandons it.
- R3: The 000h word must arrive when `line_i`/`sample_i` equal the line and sample parameters of the standard that `std_sel_i` selects (0 or 1). A correct header anywhere else leaves the field marked missing.
- R4: The three words right after 1F4h are taken as the AP, FF and ANC flag words, in that order. The packet counts as present only once the ANC word is taken. A field that ends earlier is marked missing.
- R5: In a field without a present packet, `no_pkt_o` is 1 and all three bits of `ues_o` are 1. In a field with one, `no_pkt_o` is 0.
- R6: `ues_o[1]` (AP) is 1 when bit 4 (UES) of the AP flag word is 1 or bit 8 (validity) of it is 0.
- R7: `ues_o[2]` (FF) follows the same rule with the FF flag word.
- R8: `ues_o[0]` (ANC) equals bit 4 of the ANC flag word. Bit 8 of that word has no effect.
- R9: The outputs change only at the clock edge where `field_end_i` is 1, and each field is judged on its own words only. The word presented with the strobe is discarded.
- R10: A 000h word in state GOT0, GOT1 or GOT2 restarts the header, and its position decides R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| vid_word_i | input | 10 | Received video word |
| line_i | input | LINE_W | Current line number |
| sample_i | input | SMP_W | Current sample number within the line |
| std_sel_i | input | 1 | Selected video standard (0 or 1) |
| field_end_i | input | 1 | One-cycle end-of-field strobe |
| no_pkt_o | output | 1 | Packet missing in the last finished field |
| ues_o | output | 3 | Outgoing UES bits: [0] ANC, [1] AP, [2] FF |

## Verification
The bench places correct headers one sample off the expected slot, and at the slot of the other standard. A matcher that ignored position would wrongly report a packet there. It cuts a packet short after its AP word, which catches a design that declares presence on the header alone. It corrupts one header word, which catches a matcher that checks too few words. It also sends a false start followed by a true header, which a matcher without the restart rule misses. Validity-low, UES-high and ANC-validity words each have their own field, so a swapped bit, a missing OR term or an inverted sense shows up as a wrong `ues_o` bit. Outputs are read while a new packet is arriving, which exposes a design that updates before the strobe.

// File: rtl/edh_det_pkg.sv
package edh_det_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_GOT0,
        ST_GOT1,
        ST_GOT2,
        ST_CAP_AP,
        ST_CAP_FF,
        ST_CAP_ANC,
        ST_DONE
    } hdr_state_e;

    localparam int unsigned WORD_W  = 10;
    localparam logic [WORD_W-1:0] HDR_W0 = 10'h000;
    localparam logic [WORD_W-1:0] HDR_W1 = 10'h3FF;
    localparam logic [WORD_W-1:0] HDR_W2 = 10'h3FF;
    localparam logic [WORD_W-1:0] HDR_W3 = 10'h1F4;

    localparam int unsigned UES_BIT = 4;
    localparam int unsigned VAL_BIT = 8;

    localparam int unsigned UES_ANC = 0;
    localparam int unsigned UES_AP  = 1;
    localparam int unsigned UES_FF  = 2;
    localparam int unsigned NUM_REG = 3;

    typedef struct packed {
        logic ues;
        logic valid;
    } region_flags_t;

endpackage

// File: rtl/edh_pos_match.sv
module edh_pos_match #(
    parameter int unsigned LINE_W     = 11,
    parameter int unsigned SMP_W      = 12,
    parameter int unsigned STD0_LINE  = 9,
    parameter int unsigned STD0_SMP   = 100,
    parameter int unsigned STD1_LINE  = 8,
    parameter int unsigned STD1_SMP   = 200
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [SMP_W-1:0]  sample_i,
    input  logic              std_sel_i,
    output logic              at_slot_o
);
    localparam int unsigned NUM_STD = 2;

    logic [NUM_STD-1:0] hit;

    for (genvar g = 0; g < NUM_STD; g++) begin : g_std
        localparam int unsigned L_RAW = (g == 0) ? STD0_LINE : STD1_LINE;
        localparam int unsigned S_RAW = (g == 0) ? STD0_SMP  : STD1_SMP;
        localparam logic [LINE_W-1:0] EXP_LINE = LINE_W'(L_RAW);
        localparam logic [SMP_W-1:0]  EXP_SMP  = SMP_W'(S_RAW);
        assign hit[g] = (line_i == EXP_LINE) && (sample_i == EXP_SMP);
    end

    assign at_slot_o = hit[std_sel_i];

endmodule

// File: rtl/edh_hdr_fsm.sv
module edh_hdr_fsm
    import edh_det_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              field_end_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              at_slot_i,
    output hdr_state_e        state_o,
    output logic              start_ok_o,
    output logic              pkt_done_o,
    output region_flags_t     ap_flags_o,
    output region_flags_t     ff_flags_o,
    output logic              anc_ues_o
);
    hdr_state_e state_q, state_d;
    logic       start_ok_q;
    logic       is_w0;

    assign is_w0 = (word_i == HDR_W0);

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (field_end_i) begin
            state_d = ST_HUNT;
        end else begin
            unique case (state_q)
                ST_HUNT:    state_d = is_w0 ? ST_GOT0 : ST_HUNT;
                ST_GOT0: begin
                    if (word_i == HDR_W1)  state_d = ST_GOT1;
                    else if (is_w0)        state_d = ST_GOT0;
                    else                   state_d = ST_HUNT;
                end
                ST_GOT1: begin
                    if (word_i == HDR_W2)  state_d = ST_GOT2;
                    else if (is_w0)        state_d = ST_GOT0;
                    else                   state_d = ST_HUNT;
                end
                ST_GOT2: begin
                    if (word_i == HDR_W3)  state_d = start_ok_q ? ST_CAP_AP : ST_HUNT;
                    else if (is_w0)        state_d = ST_GOT0;
                    else                   state_d = ST_HUNT;
                end
                ST_CAP_AP:  state_d = ST_CAP_FF;
                ST_CAP_FF:  state_d = ST_CAP_ANC;
                ST_CAP_ANC: state_d = ST_DONE;
                ST_DONE:    state_d = ST_DONE;
                default:    state_d = ST_HUNT;
            endcase
        end
    end

    // header start position and flag word capture
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            start_ok_q <= 1'b0;
            ap_flags_o <= '0;
            ff_flags_o <= '0;
            anc_ues_o  <= 1'b0;
        end else if (field_end_i) begin
            start_ok_q <= 1'b0;
        end else begin
            if (state_d == ST_GOT0) begin
                start_ok_q <= at_slot_i;
            end
            if (state_q == ST_CAP_AP) begin
                ap_flags_o <= '{ues: word_i[UES_BIT], valid: word_i[VAL_BIT]};
            end
            if (state_q == ST_CAP_FF) begin
                ff_flags_o <= '{ues: word_i[UES_BIT], valid: word_i[VAL_BIT]};
            end
            if (state_q == ST_CAP_ANC) begin
                anc_ues_o <= word_i[UES_BIT];
            end
        end
    end

    assign state_o    = state_q;
    assign start_ok_o = start_ok_q;
    assign pkt_done_o = (state_q == ST_DONE);

endmodule

// File: rtl/edh_ues_calc.sv
module edh_ues_calc
    import edh_det_pkg::*;
(
    input  logic               pkt_done_i,
    input  region_flags_t      ap_flags_i,
    input  region_flags_t      ff_flags_i,
    input  logic               anc_ues_i,
    output logic               missing_o,
    output logic [NUM_REG-1:0] ues_o
);
    always_comb begin
        missing_o = !pkt_done_i;
        if (missing_o) begin
            ues_o = '1;
        end else begin
            ues_o[UES_ANC] = anc_ues_i;
            ues_o[UES_AP]  = ap_flags_i.ues | ~ap_flags_i.valid;
            ues_o[UES_FF]  = ff_flags_i.ues | ~ff_flags_i.valid;
        end
    end
endmodule

// File: rtl/edh_presence_ues.sv
module edh_presence_ues
    import edh_det_pkg::*;
#(
    parameter int unsigned LINE_W    = 11,
    parameter int unsigned SMP_W     = 12,
    parameter int unsigned STD0_LINE = 9,
    parameter int unsigned STD0_SMP  = 100,
    parameter int unsigned STD1_LINE = 8,
    parameter int unsigned STD1_SMP  = 200
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [9:0]        vid_word_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [SMP_W-1:0]  sample_i,
    input  logic              std_sel_i,
    input  logic              field_end_i,
    output logic              no_pkt_o,
    output logic [2:0]        ues_o
);
    logic               at_slot;
    hdr_state_e         state;
    logic               start_ok;
    logic               pkt_done;
    region_flags_t      ap_flags, ff_flags;
    logic               anc_ues;
    logic               missing_d;
    logic [NUM_REG-1:0] ues_d;

    edh_pos_match #(
        .LINE_W(LINE_W), .SMP_W(SMP_W),
        .STD0_LINE(STD0_LINE), .STD0_SMP(STD0_SMP),
        .STD1_LINE(STD1_LINE), .STD1_SMP(STD1_SMP)
    ) u_pos (
        .line_i    (line_i),
        .sample_i  (sample_i),
        .std_sel_i (std_sel_i),
        .at_slot_o (at_slot)
    );

    edh_hdr_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .field_end_i (field_end_i),
        .word_i      (vid_word_i),
        .at_slot_i   (at_slot),
        .state_o     (state),
        .start_ok_o  (start_ok),
        .pkt_done_o  (pkt_done),
        .ap_flags_o  (ap_flags),
        .ff_flags_o  (ff_flags),
        .anc_ues_o   (anc_ues)
    );

    edh_ues_calc u_calc (
        .pkt_done_i (pkt_done),
        .ap_flags_i (ap_flags),
        .ff_flags_i (ff_flags),
        .anc_ues_i  (anc_ues),
        .missing_o  (missing_d),
        .ues_o      (ues_d)
    );

    // end-of-field output register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            no_pkt_o <= 1'b1;
            ues_o    <= '1;
        end else if (field_end_i) begin
            no_pkt_o <= missing_d;
            ues_o    <= ues_d;
        end
    end

endmodule

// File: rtl/edh_det_checker.sv
module edh_det_checker
    import edh_det_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          field_end_i,
    input  logic [9:0]    vid_word_i,
    input  logic          no_pkt_o,
    input  logic [2:0]    ues_o,
    input  hdr_state_e    state,
    input  logic          start_ok,
    input  logic          pkt_done,
    input  region_flags_t ap_flags,
    input  region_flags_t ff_flags,
    input  logic          anc_ues
);
    AST_RESET_VALUES: assert property (@(posedge clk_i)
        !rst_ni |=> (no_pkt_o && ues_o == 3'b111)); // R1

    AST_MISSING_FORCES_UES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        no_pkt_o |-> (ues_o == 3'b111)); // R5

    AST_ABSENT_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (field_end_i && !pkt_done) |=> no_pkt_o); // R4

    AST_PRESENT_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (field_end_i && pkt_done) |=> !no_pkt_o); // R5

    AST_WRONG_SLOT_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_GOT2 && vid_word_i == 10'h1F4 && !start_ok && !field_end_i)
        |=> state == ST_HUNT); // R3

    AST_AP_VALID_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (field_end_i && pkt_done && !ap_flags.valid) |=> ues_o[1]); // R6

    AST_FF_UES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (field_end_i && pkt_done && ff_flags.ues) |=> ues_o[2]); // R7

    AST_ANC_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (field_end_i && pkt_done) |=> (ues_o[0] == $past(anc_ues))); // R8

    AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !field_end_i |=> ($stable(no_pkt_o) && $stable(ues_o))); // R9

    AST_RESTART_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state == ST_GOT1 || state == ST_GOT2) && vid_word_i == 10'h000 && !field_end_i)
        |=> state == ST_GOT0); // R10

    AST_CAPTURE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_CAP_AP && !field_end_i) |=> state == ST_CAP_FF); // R4

endmodule

bind edh_presence_ues edh_det_checker u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .field_end_i (field_end_i),
    .vid_word_i  (vid_word_i),
    .no_pkt_o    (no_pkt_o),
    .ues_o       (ues_o),
    .state       (state),
    .start_ok    (start_ok),
    .pkt_done    (pkt_done),
    .ap_flags    (ap_flags),
    .ff_flags    (ff_flags),
    .anc_ues     (anc_ues)
);

// File: tb/tb_edh_presence_ues.sv
module tb_edh_presence_ues;

    localparam int unsigned LINE_W = 11;
    localparam int unsigned SMP_W  = 12;
    localparam int unsigned L0 = 9,  S0 = 100;
    localparam int unsigned L1 = 8,  S1 = 200;
    localparam logic [9:0] IDLE = 10'h040;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [9:0]        word = IDLE;
    logic [LINE_W-1:0] line = '0;
    logic [SMP_W-1:0]  smp = '0;
    logic              std_sel = 1'b0;
    logic              fend = 1'b0;
    logic              no_pkt;
    logic [2:0]        ues;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    edh_presence_ues #(
        .LINE_W(LINE_W), .SMP_W(SMP_W),
        .STD0_LINE(L0), .STD0_SMP(S0), .STD1_LINE(L1), .STD1_SMP(S1)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .vid_word_i(word), .line_i(line),
        .sample_i(smp), .std_sel_i(std_sel), .field_end_i(fend),
        .no_pkt_o(no_pkt), .ues_o(ues)
    );

    task automatic check(string req, logic exp_np, logic [2:0] exp_u);
        n_chk++;
        if (no_pkt !== exp_np || ues !== exp_u) begin
            n_bad++;
            $display("FAIL %s: got no_pkt=%b ues=%b, expected no_pkt=%b ues=%b",
                     req, no_pkt, ues, exp_np, exp_u);
        end
    endtask

    task automatic put(logic [9:0] w, int unsigned ln, int unsigned sp);
        @(negedge clk);
        word = w; line = LINE_W'(ln); smp = SMP_W'(sp); fend = 1'b0;
    endtask

    // header starting at (ln, sp), then nflag flag words
    task automatic send_pkt(int unsigned ln, int unsigned sp, logic [9:0] ap,
                            logic [9:0] ff, logic [9:0] anc, int nflag);
        logic [9:0] seq [7];
        seq = '{10'h000, 10'h3FF, 10'h3FF, 10'h1F4, ap, ff, anc};
        for (int k = 0; k < 4 + nflag; k++) put(seq[k], ln, sp + k);
    endtask

    task automatic end_field();
        @(negedge clk);
        word = IDLE; line = '0; smp = '0; fend = 1'b1;
        @(negedge clk);
        fend = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset", 1'b1, 3'b111);
    endtask

    task automatic t_good_std0();
        std_sel = 1'b0;
        put(IDLE, L0, S0 - 2);
        send_pkt(L0, S0, 10'h100, 10'h100, 10'h000, 3);
        end_field();
        check("R2/R3/R4 clean packet std0", 1'b0, 3'b000);
    endtask

    task automatic t_empty_field();
        put(IDLE, L0, S0);
        put(IDLE, L0, S0 + 1);
        end_field();
        check("R5/R9 field without packet", 1'b1, 3'b111);
    endtask

    task automatic t_ap_invalid();
        send_pkt(L0, S0, 10'h000, 10'h100, 10'h000, 3);
        end_field();
        check("R6 AP validity low", 1'b0, 3'b010);
        send_pkt(L0, S0, 10'h110, 10'h100, 10'h000, 3);
        end_field();
        check("R6 AP UES high", 1'b0, 3'b010);
    endtask

    task automatic t_ff_flags();
        send_pkt(L0, S0, 10'h100, 10'h110, 10'h000, 3);
        end_field();
        check("R7 FF UES high", 1'b0, 3'b100);
        send_pkt(L0, S0, 10'h100, 10'h000, 10'h000, 3);
        end_field();
        check("R7 FF validity low", 1'b0, 3'b100);
    endtask

    task automatic t_anc_flags();
        send_pkt(L0, S0, 10'h100, 10'h100, 10'h010, 3);
        end_field();
        check("R8 ANC UES high", 1'b0, 3'b001);
        send_pkt(L0, S0, 10'h100, 10'h100, 10'h100, 3);
        end_field();
        check("R8 ANC bit 8 ignored", 1'b0, 3'b000);
    endtask

    task automatic t_wrong_pos();
        send_pkt(L0, S0 + 1, 10'h100, 10'h100, 10'h000, 3);
        end_field();
        check("R3 header one sample late", 1'b1, 3'b111);
        send_pkt(L0 + 1, S0, 10'h100, 10'h100, 10'h000, 3);
        end_field();
        check("R3 header on wrong line", 1'b1, 3'b111);
    endtask

    task automatic t_std1();
        std_sel = 1'b1;
        send_pkt(L1, S1, 10'h100, 10'h100, 10'h000, 3);
        end_field();
        check("R3 std1 slot with std1 selected", 1'b0, 3'b000);
        send_pkt(L0, S0, 10'h100, 10'h100, 10'h000, 3);
        end_field();
        check("R3 std0 slot with std1 selected", 1'b1, 3'b111);
        std_sel = 1'b0;
    endtask

    task automatic t_bad_header();
        put(10'h000, L0, S0);
        put(10'h3FF, L0, S0 + 1);
        put(10'h3FE, L0, S0 + 2);
        put(10'h1F4, L0, S0 + 3);
        put(10'h100, L0, S0 + 4);
        put(10'h100, L0, S0 + 5);
        put(10'h000, L0, S0 + 6);
        end_field();
        check("R2 corrupted third header word", 1'b1, 3'b111);
    endtask

    task automatic t_truncated();
        send_pkt(L0, S0, 10'h100, 10'h100, 10'h000, 1);
        end_field();
        check("R4 field ends after AP word", 1'b1, 3'b111);
    endtask

    task automatic t_hold();
        send_pkt(L0, S0, 10'h100, 10'h110, 10'h000, 3);
        put(IDLE, L0, S0 + 7);
        put(IDLE, L0, S0 + 8);
        check("R9 outputs held before strobe", 1'b1, 3'b111);
        end_field();
        check("R9 outputs after strobe", 1'b0, 3'b100);
    endtask

    task automatic t_restart();
        put(10'h000, L0, S0 - 2);
        put(10'h3FF, L0, S0 - 1);
        send_pkt(L0, S0, 10'h100, 10'h100, 10'h010, 3);
        end_field();
        check("R10 restart inside header", 1'b0, 3'b001);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good_std0();
        t_empty_field();
        t_ap_invalid();
        t_ff_flags();
        t_anc_flags();
        t_wrong_pos();
        t_std1();
        t_bad_header();
        t_truncated();
        t_empty_field();
        t_hold();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule